// File: doc/BRIEF.md
# Per-VC Credit Flow Control Link

This block sits on the sending side of a router-to-router link and keeps a credit count for every virtual channel of the receiving router. Each count starts at the receiver's per-VC buffer depth. When a flit is sent on a VC, that VC's count goes down by one. When a credit tagged with that VC comes back, the count goes up by one. A VC whose count has reached zero is shown as not ready, so no flit can be sent into a buffer that is already full. The block also holds the small receiver-side path that turns "a buffered flit left, its slot is free" into a credit tagged with that VC, one cycle later.

Upstream logic offers a flit with `in_valid`, `in_vc` and `in_data`. The block reports one ready bit per VC. A flit is accepted in a cycle exactly when `in_valid` is high and `vc_ready[in_vc]` is high. While the flit is not accepted, the sender may keep `in_valid` asserted and must hold the flit. An accepted flit appears on the `flit_*` outputs in the next cycle. The link has no ready of its own, because the credit counts already guarantee space at the far end.

The turnaround is six cycles: the flit register, three receiver pipeline cycles, the credit return register and the counter update. With a buffer of 6 flits per VC, which is the default depth, one VC can be fed every cycle without a stall.

Top module: `vc_credit_link`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every `vc_ready` bit is 1, `flit_valid` is 0 and `crd_out_valid` is 0. Each count holds DEPTH.
- R2: A flit offered with `in_valid`=1 on a VC whose ready bit is 1 appears on `flit_valid`/`flit_vc`/`flit_data` in the next cycle, unchanged and in the order it was accepted.
- R3: A flit offered on a VC whose ready bit is 0 is ignored. No flit appears in the next cycle, and that VC's count does not change, so its ready bit stays 0.
- R4: Each accepted flit lowers its own VC's count by one. After DEPTH accepted flits with no credit returned, that VC's ready bit is 0 in the next cycle.
- R5: A credit (`crd_in_valid`=1, `crd_in_vc`=v) raises the count of VC v by one, so a VC at zero is ready again in the next cycle. A credit that would take a count above DEPTH is an error, and the count saturates at DEPTH.
- R6: If a flit is accepted on a VC and a credit arrives for the same VC in the same cycle, that VC's count is unchanged.
- R7: Sends and credits on one VC leave the counts and ready bits of all other VCs unchanged.
- R8: A freed receiver slot (`ds_free_valid`=1, `ds_free_vc`=v) produces `crd_out_valid`=1 with `crd_out_vc`=v in the next cycle, and `crd_out_valid`=0 otherwise.
- R9: When credits return over the six-cycle loop described above and DEPTH is 6, flits offered every cycle on one VC, or spread across VCs, are accepted every cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A flit is offered |
| in_vc | input | VCW | VC of the offered flit |
| in_data | input | DW | Payload of the offered flit |
| vc_ready | output | NUM_VC | Per-VC: at least one credit is held |
| flit_valid | output | 1 | A flit is on the link |
| flit_vc | output | VCW | VC of the link flit |
| flit_data | output | DW | Payload of the link flit |
| crd_in_valid | input | 1 | A credit returns from the receiver |
| crd_in_vc | input | VCW | VC of the returned credit |
| ds_free_valid | input | 1 | Receiver side: a buffered flit left its slot |
| ds_free_vc | input | VCW | VC of the freed slot |
| crd_out_valid | output | 1 | Credit sent back upstream |
| crd_out_vc | output | VCW | VC of the credit sent back |

## Verification
Single sends spread over different VCs show that flits are forwarded in order and that each VC keeps a count of its own. A burst of DEPTH sends on one VC, with no credit coming back, drains that VC to zero while the other VCs stay ready. A send offered after that burst then separates "blocked" from a count that has wrapped around. A send and a credit on the same VC in the same cycle, placed at a count of one, separates "held" from a count that was lowered or raised. Streaming through the closed six-cycle credit loop, on one VC and then round-robin over all VCs, shows whether a buffer of six really covers the turnaround.

// File: rtl/vc_credit_pkg.sv
package vc_credit_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_TAKE = 2'd1,
    CNT_GIVE = 2'd2
  } cnt_op_e;

  // A send and a credit on the same VC in the same cycle cancel out.
  function automatic cnt_op_e cnt_op(input logic take, input logic give);
    if (take && give) return CNT_HOLD;
    if (take)         return CNT_TAKE;
    if (give)         return CNT_GIVE;
    return CNT_HOLD;
  endfunction

endpackage

// File: rtl/vc_credit_counter.sv
module vc_credit_counter
  import vc_credit_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic has_credit
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] level;
  cnt_op_e       op;

  always_comb op = cnt_op(take, give);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= FULL;
    end else begin
      unique case (op)
        CNT_TAKE: level <= level - 1'b1;
        CNT_GIVE: level <= (level == FULL) ? level : level + 1'b1;
        default:  level <= level;
      endcase
    end
  end

  assign has_credit = (level != '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    give && !take |-> level != FULL);
  // R3
  zero_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level == '0 |-> !take);
  // R4
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !give |=> level == $past(level) - 1'b1);
  // R6
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && give |=> level == $past(level));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take && !give |=> $stable(level));

endmodule

// File: rtl/vc_credit_bank.sv
module vc_credit_bank #(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 6,
  parameter int VCW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VCW-1:0]    in_vc,
  input  logic              crd_valid,
  input  logic [VCW-1:0]    crd_vc,
  output logic [NUM_VC-1:0] vc_ready,
  output logic              accept
);
  logic [NUM_VC-1:0] take;
  logic [NUM_VC-1:0] give;

  for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
    assign take[g] = in_valid && (in_vc == VCW'(g)) && vc_ready[g];
    assign give[g] = crd_valid && (crd_vc == VCW'(g));

    vc_credit_counter #(.DEPTH(DEPTH)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take[g]),
      .give       (give[g]),
      .has_credit (vc_ready[g])
    );
  end

  assign accept = |take;

  // R7
  one_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take) && $onehot0(give));

endmodule

// File: rtl/vc_flit_stage.sv
module vc_flit_stage #(
  parameter int VCW = 2,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic [VCW-1:0] in_vc,
  input  logic [DW-1:0]  in_data,
  output logic           flit_valid,
  output logic [VCW-1:0] flit_vc,
  output logic [DW-1:0]  flit_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flit_valid <= 1'b0;
      flit_vc    <= '0;
      flit_data  <= '0;
    end else begin
      flit_valid <= accept;
      if (accept) begin
        flit_vc   <= in_vc;
        flit_data <= in_data;
      end
    end
  end

  // R2
  fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> flit_valid && flit_vc == $past(in_vc) && flit_data == $past(in_data));
  // R3
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !flit_valid);

endmodule

// File: rtl/vc_credit_return.sv
module vc_credit_return #(
  parameter int VCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           free_valid,
  input  logic [VCW-1:0] free_vc,
  output logic           crd_valid,
  output logic [VCW-1:0] crd_vc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crd_valid <= 1'b0;
      crd_vc    <= '0;
    end else begin
      crd_valid <= free_valid;
      if (free_valid) crd_vc <= free_vc;
    end
  end

  // R8
  credit_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |=> crd_valid && crd_vc == $past(free_vc));
  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !free_valid |=> !crd_valid);

endmodule

// File: rtl/vc_credit_link.sv
module vc_credit_link #(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 6,
  parameter int DW     = 32,
  localparam int VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VCW-1:0]    in_vc,
  input  logic [DW-1:0]     in_data,
  output logic [NUM_VC-1:0] vc_ready,
  output logic              flit_valid,
  output logic [VCW-1:0]    flit_vc,
  output logic [DW-1:0]     flit_data,
  input  logic              crd_in_valid,
  input  logic [VCW-1:0]    crd_in_vc,
  input  logic              ds_free_valid,
  input  logic [VCW-1:0]    ds_free_vc,
  output logic              crd_out_valid,
  output logic [VCW-1:0]    crd_out_vc
);
  logic accept;

  vc_credit_bank #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .VCW(VCW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vc     (in_vc),
    .crd_valid (crd_in_valid),
    .crd_vc    (crd_in_vc),
    .vc_ready  (vc_ready),
    .accept    (accept)
  );

  vc_flit_stage #(.VCW(VCW), .DW(DW)) u_flit (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .in_vc      (in_vc),
    .in_data    (in_data),
    .flit_valid (flit_valid),
    .flit_vc    (flit_vc),
    .flit_data  (flit_data)
  );

  vc_credit_return #(.VCW(VCW)) u_ret (
    .clk        (clk),
    .rst_n      (rst_n),
    .free_valid (ds_free_valid),
    .free_vc    (ds_free_vc),
    .crd_valid  (crd_out_valid),
    .crd_vc     (crd_out_vc)
  );

endmodule

// File: tb/vc_credit_link_bench.sv
`timescale 1ns/1ps
module vc_credit_link_bench;
  localparam int NUM_VC = 4;
  localparam int DEPTH  = 6;
  localparam int DW     = 32;
  localparam int VCW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [VCW-1:0] in_vc = '0;
  logic [DW-1:0] in_data = '0;
  logic [NUM_VC-1:0] vc_ready;
  logic flit_valid;
  logic [VCW-1:0] flit_vc;
  logic [DW-1:0] flit_data;
  logic crd_in_valid;
  logic [VCW-1:0] crd_in_vc;
  logic ds_free_valid;
  logic [VCW-1:0] ds_free_vc;
  logic crd_out_valid;
  logic [VCW-1:0] crd_out_vc;

  logic man_crd_v = 1'b0;
  logic [VCW-1:0] man_crd_vc = '0;
  logic loop_en = 1'b0;
  logic started = 1'b0;
  logic [2:0] sh_v;
  logic [VCW-1:0] sh_vc [3];
  logic e_v;
  logic [VCW-1:0] e_vc;
  int mcnt [NUM_VC];
  logic [VCW+DW-1:0] sbq [$];
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vc_credit_link u_vc_credit_link (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_data(in_data),
    .vc_ready(vc_ready), .flit_valid(flit_valid), .flit_vc(flit_vc), .flit_data(flit_data),
    .crd_in_valid(crd_in_valid), .crd_in_vc(crd_in_vc),
    .ds_free_valid(ds_free_valid), .ds_free_vc(ds_free_vc),
    .crd_out_valid(crd_out_valid), .crd_out_vc(crd_out_vc)
  );

  // Receiver model: three pipeline cycles, then slot freed; credit loops back when enabled.
  assign ds_free_valid = sh_v[2];
  assign ds_free_vc    = sh_vc[2];
  assign crd_in_valid  = loop_en ? crd_out_valid : man_crd_v;
  assign crd_in_vc     = loop_en ? crd_out_vc : man_crd_vc;

  always @(posedge clk) begin
    if (!rst_n) begin
      sh_v <= '0;
      e_v  <= 1'b0;
      for (int i = 0; i < NUM_VC; i++) mcnt[i] <= DEPTH;
    end else begin
      sh_v     <= {sh_v[1:0], flit_valid};
      sh_vc[0] <= flit_vc;
      sh_vc[1] <= sh_vc[0];
      sh_vc[2] <= sh_vc[1];
      e_v      <= ds_free_valid;
      e_vc     <= ds_free_vc;
      for (int i = 0; i < NUM_VC; i++)
        mcnt[i] <= mcnt[i]
                 - ((in_valid && vc_ready[i] && in_vc == VCW'(i)) ? 1 : 0)
                 + ((crd_in_valid && crd_in_vc == VCW'(i)) ? 1 : 0);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && started) begin
      if (flit_valid) begin
        if (sbq.size() == 0) chk(1'b0, "R2/R3 unexpected flit", longint'({flit_vc, flit_data}), 0);
        else begin
          logic [VCW+DW-1:0] exp_f;
          exp_f = sbq.pop_front();
          chk({flit_vc, flit_data} == exp_f, "R2 flit order/content",
              longint'({flit_vc, flit_data}), longint'(exp_f));
        end
      end
      for (int v = 0; v < NUM_VC; v++)
        chk(vc_ready[v] == (mcnt[v] != 0), "R4/R5/R7 ready vs credit count",
            longint'(vc_ready[v]), longint'(mcnt[v] != 0));
      chk(crd_out_valid == e_v && (!e_v || crd_out_vc == e_vc), "R8 credit return",
          longint'({crd_out_valid, crd_out_vc}), longint'({e_v, e_vc}));
    end
  end

  // Driver: one cycle of stimulus, called at posedge+1
  task automatic cyc(input bit v, input int vc, input logic [DW-1:0] d, input bit cv, input int cvc);
    in_valid   = v;
    in_vc      = VCW'(vc);
    in_data    = d;
    man_crd_v  = cv;
    man_crd_vc = VCW'(cvc);
    if (v && vc_ready[vc]) sbq.push_back({VCW'(vc), d});
    @(posedge clk); #1;
    in_valid  = 1'b0;
    man_crd_v = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    int stalls;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(vc_ready == '1, "R1 ready after reset", longint'(vc_ready), 4'hF);
    chk(!flit_valid, "R1 flit_valid after reset", longint'(flit_valid), 0);
    chk(!crd_out_valid, "R1 crd_out_valid after reset", longint'(crd_out_valid), 0);
    rst_n = 1'b1;
    chk(vc_ready == '1, "R1 ready on release", longint'(vc_ready), 4'hF);
    started = 1'b1;

    // R2: forwarding on several VCs
    cyc(1, 1, 32'hA5A5_0001, 0, 0);
    chk(flit_valid && flit_vc == 2'd1 && flit_data == 32'hA5A5_0001, "R2 first flit",
        longint'({flit_valid, flit_vc, flit_data}), longint'({1'b1, 2'd1, 32'hA5A5_0001}));
    cyc(1, 3, 32'h3C3C_0003, 0, 0);
    cyc(1, 2, 32'h0F0F_0002, 0, 0);

    // R4: drain VC0
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 32'h100 + i, 0, 0);
    chk(!vc_ready[0], "R4 VC0 empty after DEPTH sends", longint'(vc_ready[0]), 0);
    // R7: other VCs unaffected
    chk(vc_ready[3:1] == 3'b111, "R7 other VCs still ready", longint'(vc_ready[3:1]), 3'b111);

    // R3: blocked send ignored
    cyc(1, 0, 32'hDEAD_BEEF, 0, 0);
    chk(!flit_valid, "R3 blocked flit not sent", longint'(flit_valid), 0);
    chk(!vc_ready[0], "R3 VC0 count not wrapped", longint'(vc_ready[0]), 0);

    // R5: credit restores VC0
    cyc(0, 0, '0, 1, 0);
    chk(vc_ready[0], "R5 VC0 ready after credit", longint'(vc_ready[0]), 1);
    cyc(1, 0, 32'h200, 0, 0);
    chk(!vc_ready[0], "R5 single credit used", longint'(vc_ready[0]), 0);

    // R6: simultaneous send and credit on VC2 at count 1
    for (int i = 0; i < DEPTH - 2; i++) cyc(1, 2, 32'h300 + i, 0, 0);
    chk(vc_ready[2], "R6 VC2 at one credit", longint'(vc_ready[2]), 1);
    cyc(1, 2, 32'h3AA, 1, 2);
    chk(vc_ready[2], "R6 count held on send+credit", longint'(vc_ready[2]), 1);
    cyc(1, 2, 32'h3BB, 0, 0);
    chk(!vc_ready[2], "R6 count was one", longint'(vc_ready[2]), 0);

    // Restore all credits, let the receiver pipe drain
    for (int v = 0; v < NUM_VC; v++)
      while (mcnt[v] < DEPTH) cyc(0, 0, '0, 1, v);
    repeat (8) cyc(0, 0, '0, 0, 0);
    chk(vc_ready == '1, "R5 all VCs restored", longint'(vc_ready), 4'hF);

    // R9: closed credit loop, streaming
    loop_en = 1'b1;
    stalls = 0;
    for (int i = 0; i < 48; i++) begin
      if (!vc_ready[0]) stalls++;
      cyc(1, 0, 32'h500 + i, 0, 0);
    end
    chk(stalls == 0, "R9 single-VC stream without stall", stalls, 0);
    stalls = 0;
    for (int i = 0; i < 40; i++) begin
      if (!vc_ready[i % NUM_VC]) stalls++;
      cyc(1, i % NUM_VC, 32'h600 + i, 0, 0);
    end
    chk(stalls == 0, "R9 round-robin stream without stall", stalls, 0);
    repeat (10) cyc(0, 0, '0, 0, 0);
    chk(vc_ready == '1, "R9 all credits back after loop", longint'(vc_ready), 4'hF);
    chk(sbq.size() == 0, "R2 all flits delivered", sbq.size(), 0);

    report();
    $finish;
  end

endmodule